// File: doc/BRIEF.md
# Secret Key Auto-Zeroise Controller

The controller holds a 256-bit secret key as eight 32-bit words next to a key wrap/unwrap engine. It wipes that key by itself once the key has sat unused for a programmable number of clock cycles. Software reaches it through a single-cycle register port. The port lets software store key words, set the inactivity timeout, start a key initialisation or a wrap/unwrap operation, read a status word and force an immediate wipe. The engine tells the controller when key initialisation finishes and when an operation finishes. Key words can be written but can never be read back.

A three-state machine drives the controller.
- ST_IDLE: the inactivity countdown runs while a key is loaded.
- ST_BUSY: an operation is in flight and the countdown is frozen.
- ST_WIPE: the key words have been cleared and the engine is re-initialised with an all-zero key.

The transitions are:
- IDLE to BUSY on an init or next command.
- BUSY to IDLE on the engine's key-done or op-done strobe.
- IDLE to WIPE when a key is loaded and either the countdown reaches zero or a zeroise request is present.
- WIPE to IDLE on the engine's key-done strobe.

A status read reloads the countdown, so a key stays alive as long as software keeps polling.

Top module: `keyguard_ctrl`

## Requirements
- R1: A write to address 0x10+i (i = addr[2:0]) stores word i of the key. Outside ST_WIPE, `eng_key[32*i+31:32*i]` shows word i.
- R2: The timeout register at 0x0b resets to 0x0400_0000. It can be written, and a read of it returns the programmed value.
- R3: A write to the control register at 0x08 in ST_IDLE does the following. With bit 0 set, it raises `eng_init` for exactly one cycle, in the cycle after the write. With only bit 1 set, it raises `eng_next` in the same way. Bit 0 wins if both are set. Commands written outside ST_IDLE, or in a cycle where a wipe or clear is taken, are dropped.
- R4: Reads return data in the cycle after the address is presented. The status register at 0x09 gives ready on bit 0, valid on bit 1 and key-loaded on bit 2. The key words, the control register and unmapped addresses read as zero. `rdata` is zero in any cycle that follows no read.
- R5: Any read of the status register reloads the countdown with the programmed timeout, in any state.
- R6: The countdown drops by one per cycle only in ST_IDLE with a key loaded. It is frozen in ST_BUSY and ST_WIPE and whenever no key is loaded. It is reloaded when a BUSY operation completes. `timeout` is high exactly when the countdown is zero.
- R7: `eng_key_done` in ST_BUSY sets key-loaded. `eng_op_done` in ST_BUSY sets valid. Either strobe returns the controller to ST_IDLE with ready set. Starting a command clears ready and valid.
- R8: In ST_IDLE with a key loaded, a zero countdown or a zeroise request does four things: it clears all eight key words, drops ready and valid, pulses `eng_init`, and enters ST_WIPE. In ST_WIPE, `eng_key` is all zeros and `eng_keylen` is 1. On `eng_key_done`, key-loaded clears, ready sets and the state returns to ST_IDLE.
- R9: Zeroise is control bit 2. A zeroise written outside ST_IDLE is held and acted on when the controller returns to ST_IDLE. A zeroise handled in ST_IDLE with no key loaded clears the key words without starting the wipe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register access select |
| we | input | 1 | Write (1) or read (0) when selected |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the access |
| key_len256 | input | 1 | Key length selection passed to the engine outside wipes |
| eng_key_done | input | 1 | Engine strobe: key initialisation finished |
| eng_op_done | input | 1 | Engine strobe: wrap/unwrap operation finished |
| eng_init | output | 1 | One-cycle key initialisation request to the engine |
| eng_next | output | 1 | One-cycle operation request to the engine |
| eng_key | output | 256 | Key presented to the engine |
| eng_keylen | output | 1 | Key length presented to the engine |
| key_loaded | output | 1 | A key is loaded |
| timeout | output | 1 | Countdown has reached zero |

## Verification
The assertions check the countdown on every cycle: it decrements in IDLE with a key loaded, holds in BUSY and WIPE, and reloads after each status read. They also check that the key is forced to zero during WIPE, that the engine request pulses last one cycle, and that key-loaded falls only on leaving WIPE. The bench scenarios cover the rest. These include a zeroise held across a long operation, a key kept alive only by polling, a clear with no key loaded, commands dropped while busy, and the read-zero behaviour of the key and unmapped addresses.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_WIPE = 2'd2
    } kg_state_e;

    localparam logic [7:0] ADR_CTRL   = 8'h08;
    localparam logic [7:0] ADR_STATUS = 8'h09;
    localparam logic [7:0] ADR_TMO    = 8'h0b;
    localparam logic [7:0] ADR_KEY    = 8'h10;

    localparam int CB_INIT = 0;
    localparam int CB_NEXT = 1;
    localparam int CB_ZERO = 2;
endpackage

// File: rtl/keyguard_keystore.sv
module keyguard_keystore #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    localparam int SEL_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    clr,
    output logic [WORDS*DATA_W-1:0] key_flat
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (clr)
                word_q <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                word_q <= wr_data;
        end
        assign key_flat[g*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/keyguard_countdown.sv
module keyguard_countdown #(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] RST_VAL = 32'h0400_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (reload)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end
    assign is_zero = (cnt == '0);
endmodule

// File: rtl/keyguard_fsm.sv
module keyguard_fsm
    import keyguard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_init,
    input  logic      cmd_next,
    input  logic      cmd_zero,
    input  logic      key_done,
    input  logic      op_done,
    input  logic      cnt_zero,
    output kg_state_e st,
    output logic      loaded,
    output logic      valid,
    output logic      ready,
    output logic      init_p,
    output logic      next_p,
    output logic      key_clr,
    output logic      done_reload
);
    kg_state_e st_nx;
    logic      pend_q;
    logic      zreq;
    logic      wipe_go;

    assign zreq    = pend_q | cmd_zero;
    assign wipe_go = (st == ST_IDLE) && loaded && (zreq || cnt_zero);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next-state and strobes
    always_comb begin
        st_nx       = st;
        key_clr     = 1'b0;
        done_reload = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (wipe_go) begin
                    st_nx   = ST_WIPE;
                    key_clr = 1'b1;
                end else if (zreq) begin
                    key_clr = 1'b1;
                end else if (cmd_init || cmd_next) begin
                    st_nx = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (key_done || op_done) begin
                    st_nx       = ST_IDLE;
                    done_reload = 1'b1;
                end
            end
            ST_WIPE: begin
                if (key_done) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded <= 1'b0;
            valid  <= 1'b0;
            ready  <= 1'b1;
            init_p <= 1'b0;
            next_p <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            init_p <= 1'b0;
            next_p <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (zreq || wipe_go) pend_q <= 1'b0;
                    if (wipe_go) begin
                        init_p <= 1'b1;
                        ready  <= 1'b0;
                        valid  <= 1'b0;
                    end else if (!zreq && (cmd_init || cmd_next)) begin
                        init_p <= cmd_init;
                        next_p <= !cmd_init;
                        ready  <= 1'b0;
                        valid  <= 1'b0;
                    end
                end
                ST_BUSY: begin
                    if (cmd_zero) pend_q <= 1'b1;
                    if (key_done) begin
                        loaded <= 1'b1;
                        ready  <= 1'b1;
                    end else if (op_done) begin
                        valid <= 1'b1;
                        ready <= 1'b1;
                    end
                end
                ST_WIPE: begin
                    if (cmd_zero) pend_q <= 1'b1;
                    if (key_done) begin
                        loaded <= 1'b0;
                        ready  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/keyguard_ctrl.sv
module keyguard_ctrl
    import keyguard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int KEY_WORDS = 8,
    parameter int ADDR_W = 8,
    parameter logic [31:0] DEF_TIMEOUT = 32'h0400_0000,
    localparam int KEY_W = DATA_W * KEY_WORDS,
    localparam int SEL_W = $clog2(KEY_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              key_len256,
    input  logic              eng_key_done,
    input  logic              eng_op_done,
    output logic              eng_init,
    output logic              eng_next,
    output logic [KEY_W-1:0]  eng_key,
    output logic              eng_keylen,
    output logic              key_loaded,
    output logic              timeout
);
    logic              wr, rd, ctrl_wr, stat_rd, tmo_wr, key_wr;
    logic              valid_f, ready_f, key_clr, done_reload, cnt_zero;
    logic [DATA_W-1:0] tmo_q, cnt_val, rd_mux;
    logic [KEY_W-1:0]  key_flat;
    kg_state_e         fsm_st;

    assign wr      = cs & we;
    assign rd      = cs & ~we;
    assign ctrl_wr = wr && addr == ADDR_W'(ADR_CTRL);
    assign tmo_wr  = wr && addr == ADDR_W'(ADR_TMO);
    assign stat_rd = rd && addr == ADDR_W'(ADR_STATUS);
    assign key_wr  = wr && (addr >> SEL_W) == (ADDR_W'(ADR_KEY) >> SEL_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tmo_q <= DATA_W'(DEF_TIMEOUT);
        else if (tmo_wr) tmo_q <= wdata;
    end

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(ADR_STATUS))
            rd_mux = DATA_W'({key_loaded, valid_f, ready_f});
        else if (addr == ADDR_W'(ADR_TMO))
            rd_mux = tmo_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd ? rd_mux : '0;
    end

    keyguard_keystore #(.DATA_W(DATA_W), .WORDS(KEY_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(key_wr), .wr_sel(addr[SEL_W-1:0]),
        .wr_data(wdata), .clr(key_clr), .key_flat(key_flat)
    );

    keyguard_countdown #(.CNT_W(DATA_W), .RST_VAL(DATA_W'(DEF_TIMEOUT))) u_cnt (
        .clk(clk), .rst_n(rst_n), .reload(stat_rd | done_reload),
        .dec(fsm_st == ST_IDLE && key_loaded), .load_val(tmo_q),
        .cnt(cnt_val), .is_zero(cnt_zero)
    );

    keyguard_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_init(ctrl_wr & wdata[CB_INIT]), .cmd_next(ctrl_wr & wdata[CB_NEXT]),
        .cmd_zero(ctrl_wr & wdata[CB_ZERO]),
        .key_done(eng_key_done), .op_done(eng_op_done), .cnt_zero(cnt_zero),
        .st(fsm_st), .loaded(key_loaded), .valid(valid_f), .ready(ready_f),
        .init_p(eng_init), .next_p(eng_next), .key_clr(key_clr),
        .done_reload(done_reload)
    );

    assign eng_key    = (fsm_st == ST_WIPE) ? '0 : key_flat;
    assign eng_keylen = (fsm_st == ST_WIPE) ? 1'b1 : key_len256;
    assign timeout    = cnt_zero;
endmodule

// File: rtl/keyguard_ctrl_chk.sv
module keyguard_ctrl_chk
    import keyguard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int KEY_W = 256,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              eng_key_done,
    input logic              eng_op_done,
    input logic              eng_init,
    input logic              eng_next,
    input logic [KEY_W-1:0]  eng_key,
    input logic              eng_keylen,
    input logic              key_loaded,
    input kg_state_e         fsm_st,
    input logic [DATA_W-1:0] cnt_val,
    input logic [DATA_W-1:0] tmo_q
);
    logic stat_rd;
    assign stat_rd = cs && !we && addr == ADDR_W'(ADR_STATUS);

    p_no_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !we) |=> rdata == '0);

    p_init_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_init |=> !eng_init);

    p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_init && eng_next));

    p_status_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> cnt_val == $past(tmo_q));

    p_idle_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == ST_IDLE && key_loaded && cnt_val != '0 && !stat_rd)
        |=> cnt_val == DATA_W'($past(cnt_val) - 1));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st != ST_IDLE && !stat_rd && !eng_key_done && !eng_op_done)
        |=> $stable(cnt_val));

    p_wipe_zero_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_st == ST_WIPE |-> (eng_key == '0 && eng_keylen));

    p_unload_from_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_loaded) |-> $past(fsm_st) == ST_WIPE);
endmodule

bind keyguard_ctrl keyguard_ctrl_chk #(.DATA_W(DATA_W), .KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .rdata(rdata),
    .eng_key_done(eng_key_done), .eng_op_done(eng_op_done),
    .eng_init(eng_init), .eng_next(eng_next), .eng_key(eng_key),
    .eng_keylen(eng_keylen), .key_loaded(key_loaded), .fsm_st(fsm_st),
    .cnt_val(cnt_val), .tmo_q(tmo_q)
);

// File: tb/tb_keyguard_ctrl.sv
module tb_keyguard_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, we = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         key_len256 = 1'b0;
    logic         eng_key_done = 1'b0, eng_op_done = 1'b0;
    logic         eng_init, eng_next, eng_keylen, key_loaded, timeout;
    logic [255:0] eng_key;

    int errors = 0, checks = 0, cycles = 0;
    int rsp_delay = 3, rsp_left = 0, rsp_kind = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    keyguard_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .key_len256(key_len256), .eng_key_done(eng_key_done),
        .eng_op_done(eng_op_done), .eng_init(eng_init), .eng_next(eng_next),
        .eng_key(eng_key), .eng_keylen(eng_keylen), .key_loaded(key_loaded),
        .timeout(timeout)
    );

    // Behavioural reference model
    logic [31:0] m_key [8];
    logic [31:0] m_tmo, m_cnt, m_rdata;
    int          m_mode;              // 0 idle, 1 busy, 2 wipe
    bit          m_loaded, m_valid, m_ready, m_pend, m_init, m_next;

    always @(posedge clk or negedge rst_n) begin : model
        bit wr, rd, c_i, c_n, c_z, zr, clr, rel, dec;
        if (!rst_n) begin
            foreach (m_key[i]) m_key[i] = '0;
            m_tmo = 32'h0400_0000; m_cnt = 32'h0400_0000; m_rdata = '0;
            m_mode = 0; m_loaded = 0; m_valid = 0; m_ready = 1; m_pend = 0;
            m_init = 0; m_next = 0;
        end else begin
            wr = cs && we; rd = cs && !we;
            c_i = wr && addr == 8'h08 && wdata[0];
            c_n = wr && addr == 8'h08 && wdata[1];
            c_z = wr && addr == 8'h08 && wdata[2];
            m_rdata = !rd ? 32'h0 : (addr == 8'h09) ? {29'h0, m_loaded, m_valid, m_ready}
                    : (addr == 8'h0b) ? m_tmo : 32'h0;
            dec = (m_mode == 0) && m_loaded;
            rel = rd && addr == 8'h09;
            clr = 0; m_init = 0; m_next = 0;
            zr = m_pend || c_z;
            if (m_mode == 0) begin
                if (m_loaded && (zr || m_cnt == 0)) begin
                    clr = 1; m_pend = 0; m_mode = 2; m_init = 1; m_ready = 0; m_valid = 0;
                end else if (zr) begin
                    clr = 1; m_pend = 0;
                end else if (c_i || c_n) begin
                    m_mode = 1; m_init = c_i; m_next = !c_i; m_ready = 0; m_valid = 0;
                end
            end else if (m_mode == 1) begin
                if (c_z) m_pend = 1;
                if (eng_key_done) begin m_loaded = 1; m_ready = 1; m_mode = 0; rel = 1; end
                else if (eng_op_done) begin m_valid = 1; m_ready = 1; m_mode = 0; rel = 1; end
            end else begin
                if (c_z) m_pend = 1;
                if (eng_key_done) begin m_loaded = 0; m_ready = 1; m_mode = 0; end
            end
            if (rel) m_cnt = m_tmo;
            else if (dec && m_cnt != 0) m_cnt = m_cnt - 1;
            if (wr && addr == 8'h0b) m_tmo = wdata;
            if (clr) foreach (m_key[i]) m_key[i] = '0;
            else if (wr && addr[7:3] == 5'b00010) m_key[addr[2:0]] = wdata;
        end
    end

    task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [255:0] m_keybus();
        logic [255:0] k;
        for (int i = 0; i < 8; i++) k[32*i +: 32] = m_key[i];
        return (m_mode == 2) ? 256'h0 : k;
    endfunction

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 rdata", 256'(rdata), 256'(m_rdata));
            chk("R7 key_loaded", 256'(key_loaded), 256'(m_loaded));
            chk("R6 timeout", 256'(timeout), 256'(m_cnt == 0));
            chk("R3 eng_init", 256'(eng_init), 256'(m_init));
            chk("R3 eng_next", 256'(eng_next), 256'(m_next));
            chk("R1/R8 eng_key", eng_key, m_keybus());
            chk("R8 eng_keylen", 256'(eng_keylen), 256'(m_mode == 2 ? 1'b1 : key_len256));
        end
    end

    // Engine responder
    always @(negedge clk) begin
        eng_key_done = 0; eng_op_done = 0;
        if (rsp_left > 0) begin
            rsp_left--;
            if (rsp_left == 0) begin
                if (rsp_kind == 1) eng_key_done = 1; else eng_op_done = 1;
            end
        end
        if (eng_init) begin rsp_left = rsp_delay; rsp_kind = 1; end
        else if (eng_next) begin rsp_left = rsp_delay; rsp_kind = 2; end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); cs = 1; we = 0; addr = a;
        @(negedge clk); cs = 0; d = rdata;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++; done = 1;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R4 reset rdata", 256'(rdata), 0);
        chk("R7 reset loaded", 256'(key_loaded), 0);
        rd(8'h0b, v); chk("R2 default timeout", 256'(v), 256'(32'h0400_0000));
        rd(8'h09, v); chk("R4 status after reset", 256'(v), 1);
        for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i), 32'hA000_0000 + 32'(i) * 32'h1111);
        chk("R1 key word 3", 256'(eng_key[127:96]), 256'(32'hA000_3333));
        rd(8'h13, v); chk("R4 key not readable", 256'(v), 0);
        rd(8'h55, v); chk("R4 unmapped reads zero", 256'(v), 0);
        rd(8'h08, v); chk("R4 control reads zero", 256'(v), 0);
        wr(8'h0b, 32'd20);
        rd(8'h0b, v); chk("R2 timeout readback", 256'(v), 20);
        // Key init
        wr(8'h08, 32'h1); idle(8);
        chk("R7 loaded after init", 256'(key_loaded), 1);
        rd(8'h09, v); chk("R4 status loaded+ready", 256'(v), 5);
        // Keep alive by polling
        idle(12); rd(8'h09, v); idle(15);
        chk("R5 polling keeps key", 256'(key_loaded), 1);
        idle(30);
        chk("R8 timeout wipes key", 256'(key_loaded), 0);
        chk("R8 key words cleared", eng_key, 0);
        // Operation, valid flag
        wr(8'h08, 32'h1); idle(8);
        wr(8'h08, 32'h2); idle(8);
        rd(8'h09, v); chk("R7 status valid", 256'(v), 7);
        // Long operation with held zeroise and ignored init
        rsp_delay = 30;
        wr(8'h08, 32'h2); wr(8'h08, 32'h4); wr(8'h08, 32'h1);
        idle(24);
        chk("R6 countdown frozen while busy", 256'(key_loaded), 1);
        idle(50);
        chk("R9 held zeroise wiped key", 256'(key_loaded), 0);
        rsp_delay = 3;
        // Zeroise with no key loaded
        wr(8'h10, 32'h1234);
        chk("R1 word written", 256'(eng_key[31:0]), 256'(32'h1234));
        wr(8'h08, 32'h4); idle(2);
        chk("R9 clear without load", eng_key, 0);
        // Zeroise while loaded, wipe forces keylen
        wr(8'h08, 32'h1); idle(8);
        wr(8'h08, 32'h4);
        chk("R8 keylen forced in wipe", 256'(eng_keylen), 1);
        idle(8);
        chk("R8 loaded cleared", 256'(key_loaded), 0);
        rd(8'h09, v); chk("R8 ready restored", 256'(v), 1);
        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule